// File: doc/BRIEF.md
# Two-Wire Bus Master Receive Word Engine

This block is the receive half of a two-wire serial bus master. Once the surrounding controller signals that the address phase is over, the engine holds the clock line low and waits. Each read of the data register by software releases the line. The engine then clocks in one word of one to eight bits, most significant bit first. It can add a ninth acknowledge clock, during which it pulls the data line low itself. At the end of the word it pulses an interrupt, drops its pending flag and holds the clock low again until the next read.

The word length and the acknowledge option are taken from the host port at the moment of the releasing read. Software can therefore shorten the last word or drop the acknowledge before it issues the final read. Each clock phase lasts a number of system clocks set by a prescaler input. The high phase counts only while the clock line is actually seen high, so a slave that stretches the clock delays the engine. The value returned by the very first read after the address phase has no meaning; that read only starts reception.

Top module: `twi_rx_engine`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0 (both lines released), pending is 0, irq is 0 and rd_data is 0.
- R2: Until addr_done has been seen, data reads have no effect and SCL stays released. One cycle after addr_done, scl_oe is 1 and pending is 0.
- R3: While SCL is held between words, a data read with xmit_sel=0 sets pending to 1 in the following cycle and starts clocking. A read with xmit_sel=1 is ignored.
- R4: A word has N data clocks, where N is bit_cnt, or 8 when bit_cnt is 3'b000. One more clock is added when ack_en=1. Each SCL low and high phase lasts presc+1 system clocks. irq is seen 2*(N+ack_en)*(presc+1) cycles after the clock edge that takes the read.
- R5: SDA is sampled in the first cycle of each SCL high phase, MSB first. At completion rd_data holds the received bits right-aligned, and the unused upper bits are 0.
- R6: With ack_en=1, sda_oe is 1 for the whole low and high phase of the acknowledge clock, which is 2*(presc+1) cycles, and 0 otherwise. With ack_en=0, sda_oe stays 0 for the whole word.
- R7: At completion, irq is 1 for exactly one cycle, pending returns to 0, and SCL stays held low (scl_oe=1) until the next read.
- R8: bit_cnt and ack_en are captured at the releasing read. Changing them while a word is in progress does not change that word.
- R9: A data write (dat_wr) in receive mode is ignored: pending, SCL and rd_data do not change.
- R10: The SCL high phase counts only cycles in which scl_i is 1. A slave holding SCL low for S extra cycles delays completion by S cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_done | input | 1 | Pulse: address phase finished, arm the engine |
| xmit_sel | input | 1 | 1 = transmit selected, 0 = receive |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe (ignored) |
| bit_cnt | input | 3 | Data bits per word, 0 means 8 |
| ack_en | input | 1 | Add an acknowledge clock driven low |
| presc | input | 8 | SCL phase length minus one, in system clocks |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| rd_data | output | 8 | Last received word, right-aligned |
| pending | output | 1 | Word transfer in progress |
| irq | output | 1 | One-cycle pulse at word completion |

## Verification
pending rises in the first cycle after the edge that takes the read. irq follows exactly 2*(N+ack)*(presc+1) edges after that edge, plus any stretch cycles. The bench counts falling clock edges from the read edge and requires irq in that exact one, then checks rd_data, pending and scl_oe in the same sample, and checks irq low in the next. Acknowledge timing is checked by counting the sampled cycles with sda_oe high over the whole word. The bench also acts as the slave: it changes SDA on each observed SCL fall, so data is settled long before the sampling edge.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } twi_st_e;
endpackage

// File: rtl/twi_phase_timer.sv
module twi_phase_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          run,
  output logic [PW-1:0] cnt,
  output logic          expired
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/twi_rx_shifter.sv
module twi_rx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift,
  input  logic          bit_in,
  input  logic          capture,
  output logic [DW-1:0] word
);
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] word_q, word_d;

  always_comb begin
    sh_d = sh_q;
    if (clear)
      sh_d = '0;
    else if (shift)
      sh_d = {sh_q[DW-2:0], bit_in};
    word_d = capture ? sh_d : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/twi_rx_engine.sv
module twi_rx_engine #(
  parameter int DW = 8,
  parameter int PW = 8,
  localparam int CW = $clog2(DW),
  localparam int LW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_done,
  input  logic          xmit_sel,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [CW-1:0] bit_cnt,
  input  logic          ack_en,
  input  logic [PW-1:0] presc,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [DW-1:0] rd_data,
  output logic          pending,
  output logic          irq
);
  import twi_rx_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  twi_st_e       st_q, st_d;
  logic [LW-1:0] left_q, left_d;
  logic          ack_q, ack_d;
  logic [PW-1:0] presc_q, presc_d;
  logic          irq_q, irq_d;

  logic          start, low_end, high_end, last_clk, ack_slot, sample;
  logic          tmr_load, tmr_run, tmr_zero;
  logic [PW-1:0] tmr_cnt, tmr_val;
  logic [LW-1:0] nbits;

  assign nbits    = (bit_cnt == '0) ? LW'(DW) : LW'(bit_cnt);
  assign start    = (st_q == ST_HOLD) && dat_rd && !xmit_sel;
  assign last_clk = (left_q == LW'(1));
  assign ack_slot = ack_q && last_clk;
  assign low_end  = (st_q == ST_LOW) && tmr_zero;
  assign high_end = (st_q == ST_HIGH) && scl_i && tmr_zero;
  assign sample   = (st_q == ST_HIGH) && scl_i && (tmr_cnt == presc_q) && !ack_slot;

  assign tmr_load = start || low_end || (high_end && !last_clk);
  assign tmr_run  = (st_q == ST_LOW) || ((st_q == ST_HIGH) && scl_i);
  assign tmr_val  = start ? presc : presc_q;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    ack_d   = ack_q;
    presc_d = presc_q;
    irq_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (addr_done) st_d = ST_HOLD;
      ST_HOLD: if (start) begin
        st_d    = ST_LOW;
        left_d  = nbits + LW'(ack_en);
        ack_d   = ack_en;
        presc_d = presc;
      end
      ST_LOW:  if (low_end) st_d = ST_HIGH;
      ST_HIGH: if (high_end) begin
        if (last_clk) begin
          st_d  = ST_HOLD;
          irq_d = 1'b1;
        end else begin
          st_d   = ST_LOW;
          left_d = left_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      left_q  <= '0;
      ack_q   <= 1'b0;
      presc_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      left_q  <= left_d;
      ack_q   <= ack_d;
      presc_q <= presc_d;
      irq_q   <= irq_d;
    end
  end

  twi_phase_timer #(.PW(PW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .cnt      (tmr_cnt),
    .expired  (tmr_zero)
  );

  twi_rx_shifter #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (start),
    .shift   (sample),
    .bit_in  (sda_i),
    .capture (high_end && last_clk),
    .word    (rd_data)
  );

  assign pending = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign scl_oe  = (st_q == ST_HOLD) || (st_q == ST_LOW);
  assign sda_oe  = pending && ack_slot;
  assign irq     = irq_q;
endmodule

// File: rtl/twi_rx_engine_chk.sv
module twi_rx_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dat_rd,
  input logic          dat_wr,
  input logic          xmit_sel,
  input logic          scl_i,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [DW-1:0] rd_data,
  input logic          pending,
  input logic          irq
);
  p_read_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !xmit_sel && scl_oe && !pending) |=> pending);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!pending && scl_oe));

  p_ack_in_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> pending);

  p_data_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> irq);

  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !dat_rd && !pending) |=> (!pending && $stable(rd_data)));

  p_stretch_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !scl_oe && !scl_i) |=> pending);
endmodule

bind twi_rx_engine twi_rx_engine_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dat_rd   (dat_rd),
  .dat_wr   (dat_wr),
  .xmit_sel (xmit_sel),
  .scl_i    (scl_i),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .rd_data  (rd_data),
  .pending  (pending),
  .irq      (irq)
);

// File: tb/tb_twi_rx_engine.sv
`timescale 1ns/1ps
module tb_twi_rx_engine;
  logic       clk = 1'b0;
  logic       rst_n, addr_done, xmit_sel, dat_rd, dat_wr, ack_en;
  logic [2:0] bit_cnt;
  logic [7:0] presc, rd_data;
  logic       scl_i, scl_oe, sda_i, sda_oe, pending, irq;
  logic       stretch, slave_sda;
  int         nchk = 0, nerr = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  assign scl_i = ~scl_oe & ~stretch;
  assign sda_i = ~sda_oe & slave_sda;

  twi_rx_engine dut (
    .clk(clk), .rst_n(rst_n), .addr_done(addr_done), .xmit_sel(xmit_sel),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .bit_cnt(bit_cnt), .ack_en(ack_en),
    .presc(presc), .scl_i(scl_i), .scl_oe(scl_oe), .sda_i(sda_i),
    .sda_oe(sda_oe), .rd_data(rd_data), .pending(pending), .irq(irq)
  );

  // {bit_cnt, ack_en, presc, slave pattern}
  localparam logic [19:0] VEC [6] = '{
    {3'd0, 1'b1, 8'd2, 8'hA5},
    {3'd3, 1'b1, 8'd1, 8'hFF},
    {3'd5, 1'b0, 8'd0, 8'h35},
    {3'd1, 1'b1, 8'd0, 8'h01},
    {3'd7, 1'b0, 8'd3, 8'h5A},
    {3'd0, 1'b0, 8'd0, 8'h3C}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run_word(input logic [2:0] bc, input logic ak, input logic [7:0] p,
                          input logic [7:0] pat, input int s, input bit midchg);
    int   n    = (bc == 3'd0) ? 8 : int'(bc);
    int   tot  = 2 * (n + int'(ak)) * (int'(p) + 1) + s;
    int   ackx = ak ? 2 * (int'(p) + 1) : 0;
    logic [7:0] expd = pat & 8'((1 << n) - 1);
    int   ackc = 0;
    int   idx  = n - 1;
    int   i    = 0;
    bit   done = 0;
    logic prev;
    @(negedge clk);
    bit_cnt = bc; ack_en = ak; presc = p;
    slave_sda = pat[idx]; stretch = (s > 0); dat_rd = 1'b1;
    @(posedge clk); #1 dat_rd = 1'b0;
    prev = scl_i;
    while (!done && i < 5000) begin
      @(negedge clk);
      if (i == 0) chk(pending == 1'b1, "R3 pending after read", pending, 1);
      if (irq) done = 1;
      else begin
        if (sda_oe) ackc++;
        if (midchg && i == 1) begin bit_cnt = bc ^ 3'b101; ack_en = ~ak; end
        if (prev && !scl_i) begin
          idx--;
          slave_sda = (idx >= 0) ? pat[idx] : 1'b1;
        end
        prev = scl_i;
        if (i == int'(p) + s + 1) stretch = 1'b0;
        i++;
      end
    end
    stretch = 1'b0;
    chk(i == tot, s > 0 ? "R10 completion cycle with stretch" :
                  (midchg ? "R8 completion cycle after mid-word change" : "R4 completion cycle"), i, tot);
    chk(rd_data == expd, midchg ? "R8 data length kept" : "R5 received word", rd_data, expd);
    chk(ackc == ackx, "R6 sda_oe cycles", ackc, ackx);
    chk(!pending && scl_oe, "R7 pending cleared, SCL held", {pending, scl_oe}, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq one cycle", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_done = 1'b0; xmit_sel = 1'b0; dat_rd = 1'b0; dat_wr = 1'b0;
    ack_en = 1'b0; bit_cnt = 3'd0; presc = 8'd0; stretch = 1'b0; slave_sda = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!pending && !irq, "R1 pending/irq low", {pending, irq}, 0);
    chk(rd_data == 8'h00, "R1 rd_data zero", rd_data, 0);
    // R2 read before address phase ignored
    dat_rd = 1'b1; @(negedge clk); dat_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pending && !scl_oe, "R2 read ignored before addr_done", {pending, scl_oe}, 0);
    addr_done = 1'b1; @(negedge clk); addr_done = 1'b0;
    chk(scl_oe && !pending, "R2 SCL held after addr_done", {scl_oe, pending}, 2);
    // R3 read in transmit mode ignored
    xmit_sel = 1'b1; dat_rd = 1'b1; @(negedge clk); dat_rd = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pending && scl_oe, "R3 read ignored with xmit_sel=1", pending, 0);
    xmit_sel = 1'b0;
    // R9 write ignored
    dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pending && scl_oe && rd_data == 8'h00, "R9 write ignored", rd_data, 0);
    // table of words, lengths and ack change between reads
    for (int k = 0; k < 6; k++)
      run_word(VEC[k][19:17], VEC[k][16], VEC[k][15:8], VEC[k][7:0], 0, 1'b0);
    // R10 clock stretching by the slave
    run_word(3'd0, 1'b1, 8'd1, 8'h96, 5, 1'b0);
    // R8 mid-word change of length and ack
    run_word(3'd4, 1'b0, 8'd1, 8'h0B, 0, 1'b1);
    // R9 write after a word leaves data unchanged
    dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
    @(negedge clk);
    chk(rd_data == 8'h0B && !pending, "R9 write keeps rd_data", rd_data, 8'h0B);
    // R7 SCL held while no read arrives
    repeat (6) @(negedge clk);
    chk(scl_oe && !pending && !irq, "R7 hold until read", {scl_oe, pending, irq}, 4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule